// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one capture/compare channel that sits beside a free-running 16-bit timer. Software picks one of two modes. In compare mode the channel holds a value. It raises its interrupt flag on the timer clock edge at which the timer count equals that value. In capture mode the channel watches one of four selectable levels: two external capture pins, a constant low and a constant high. When that level shows the chosen kind of transition, the channel copies the timer count into its register and raises the flag.

Software capture needs no extra hardware. With the edge mode set to both edges, software switches the input select between the constant-low and constant-high choices. Each switch looks like an edge and causes one capture. The selected level passes through a two-stage synchronizer before edge detection.

The flag drives the channel's own interrupt request through an enable gate. The flag clears itself when the interrupt controller reports that the request was accepted. An overflow bit records that a capture overwrote a value that software had not yet read.

Top module: `cap_cmp_channel`

## Requirements
- R1: While `rstN` is low, `regValue` is 0 and `flag`, `irq` and `overflow` are 0.
- R2: With `capModeEn`=0, `flag` becomes 1 after the clock edge at which `timerCount` equals `regValue`. It is not set at earlier edges.
- R3: With `capModeEn`=1, suppose a qualifying change of the selected level is first sampled at edge E0. Then at edge E2 (two edges later) `regValue` loads the `timerCount` present at E2, and `flag` becomes 1.
- R4: `edgeSel` encoding: 0 = no capture, 1 = low-to-high only, 2 = high-to-low only, 3 = either direction. A non-qualifying transition leaves `regValue` unchanged.
- R5: `inSel` encoding: 0 = `capInA`, 1 = `capInB`, 2 = constant 0, 3 = constant 1. A transition on an unselected pin has no effect. With `edgeSel`=3, each switch of `inSel` between 2 and 3 causes one capture.
- R6: `irq` equals `flag` AND `intEnable`, combinationally.
- R7: `intAck` clears `flag` at the next edge. If a set event occurs at that same edge, the flag stays 1.
- R8: A capture that would occur at the edge where `capModeEn` is 1 for the first cycle (it was 0 at the previous edge) is ignored. Captures work from the following cycle.
- R9: `wrEn` loads `wrData` into `regValue` at the next edge. If a capture occurs at that same edge, the captured count is loaded instead.
- R10: `overflow` becomes 1 when a capture occurs while the previous captured value is still unread. `rdStrobe` clears it and marks the value as read. A read and a capture at the same edge leave `overflow` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Asynchronous reset, active low |
| timerCount | input | 16 | Current count of the free-running timer |
| capInA | input | 1 | Capture pin A |
| capInB | input | 1 | Capture pin B |
| inSel | input | 2 | Capture level select (see R5) |
| capModeEn | input | 1 | 1 = capture mode, 0 = compare mode |
| edgeSel | input | 2 | Capture edge select (see R4) |
| intEnable | input | 1 | Interrupt enable |
| intAck | input | 1 | Interrupt accepted strobe |
| wrEn | input | 1 | Software write strobe for the register |
| wrData | input | 16 | Software write data |
| rdStrobe | input | 1 | Software read of the captured value |
| regValue | output | 16 | Compare/capture register |
| flag | output | 1 | Interrupt flag |
| irq | output | 1 | Interrupt request of this channel |
| overflow | output | 1 | Capture overrun indicator |

## Verification
The results of this block become due at different times:

- A compare match and a software write appear after the same edge that sees them.
- An acknowledge clears the flag one edge later.
- The request output follows the enable without any clock.
- A capture appears two edges after the first edge that samples the new level, because of the two synchronizer stages.

The directed checks drive inputs on the falling clock and count whole cycles to the edge where each effect is due. For a capture, the expected value is the timer count three cycles after the level change. The checks also sample one edge before that point, to catch early loading. A behavioural model keeps a short queue of sampled levels and is compared with every output just after each rising edge.

// File: rtl/cc_chan_pkg.sv
package cc_chan_pkg;

  localparam logic [1:0] EDGE_NONE = 2'd0;
  localparam logic [1:0] EDGE_RISE = 2'd1;
  localparam logic [1:0] EDGE_FALL = 2'd2;
  localparam logic [1:0] EDGE_BOTH = 2'd3;

  localparam logic [1:0] SEL_PIN_A = 2'd0;
  localparam logic [1:0] SEL_PIN_B = 2'd1;
  localparam logic [1:0] SEL_LOW   = 2'd2;
  localparam logic [1:0] SEL_HIGH  = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCapture;
    logic loadWrite;
    logic setFlag;
  } ccStrobe_t;

endpackage

// File: rtl/cc_chan_ctrl.sv
module cc_chan_ctrl
  import cc_chan_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       capInA,
  input  logic       capInB,
  input  logic [1:0] inSel,
  input  logic       capModeEn,
  input  logic [1:0] edgeSel,
  input  logic       wrEn,
  input  logic       cmpEq,
  output ccStrobe_t  strb
);

  localparam int LAST = SYNC_STAGES - 1;

  logic             selLevel;
  logic [LAST:0]    syncQ;
  logic             prevLvl;
  logic             modeQ;
  logic             riseSeen;
  logic             fallSeen;
  logic             edgeHit;
  logic             capTrig;

  always_comb begin
    unique case (inSel)
      SEL_PIN_A: selLevel = capInA;
      SEL_PIN_B: selLevel = capInB;
      SEL_LOW:   selLevel = 1'b0;
      default:   selLevel = 1'b1;
    endcase
  end

  // synchronizer chain plus one history stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '0;
      prevLvl <= 1'b0;
      modeQ   <= 1'b0;
    end else begin
      syncQ[0] <= selLevel;
      for (int i = 1; i < SYNC_STAGES; i++) syncQ[i] <= syncQ[i-1];
      prevLvl <= syncQ[LAST];
      modeQ   <= capModeEn;
    end
  end

  assign riseSeen = syncQ[LAST] & ~prevLvl;
  assign fallSeen = ~syncQ[LAST] & prevLvl;

  always_comb begin
    unique case (edgeSel)
      EDGE_RISE: edgeHit = riseSeen;
      EDGE_FALL: edgeHit = fallSeen;
      EDGE_BOTH: edgeHit = riseSeen | fallSeen;
      default:   edgeHit = 1'b0;
    endcase
  end

  // a capture on the first cycle of capture mode is dropped
  assign capTrig = capModeEn & modeQ & edgeHit;

  always_comb begin
    strb.loadCapture = capTrig;
    strb.loadWrite   = wrEn & ~capTrig;
    strb.setFlag     = capTrig | (~capModeEn & cmpEq);
  end

endmodule

// File: rtl/cc_chan_datapath.sv
module cc_chan_datapath
  import cc_chan_pkg::*;
#(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  ccStrobe_t          strb,
  input  logic [TIMER_W-1:0] timerCount,
  input  logic [TIMER_W-1:0] wrData,
  input  logic               intAck,
  input  logic               rdStrobe,
  output logic [TIMER_W-1:0] regValue,
  output logic               flag,
  output logic               overflow,
  output logic               cmpEq
);

  logic [TIMER_W-1:0] regQ;
  logic               flagQ;
  logic               ovfQ;
  logic               unreadQ;

  assign cmpEq = (timerCount == regQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regQ    <= '0;
      flagQ   <= 1'b0;
      ovfQ    <= 1'b0;
      unreadQ <= 1'b0;
    end else begin
      if (strb.loadCapture)    regQ <= timerCount;
      else if (strb.loadWrite) regQ <= wrData;

      if (strb.setFlag)  flagQ <= 1'b1;
      else if (intAck)   flagQ <= 1'b0;

      if (rdStrobe)                         ovfQ <= 1'b0;
      else if (strb.loadCapture && unreadQ) ovfQ <= 1'b1;

      if (strb.loadCapture) unreadQ <= 1'b1;
      else if (rdStrobe)    unreadQ <= 1'b0;
    end
  end

  assign regValue = regQ;
  assign flag     = flagQ;
  assign overflow = ovfQ;

endmodule

// File: rtl/cap_cmp_channel.sv
module cap_cmp_channel
  import cc_chan_pkg::*;
#(
  parameter int TIMER_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TIMER_W-1:0] timerCount,
  input  logic               capInA,
  input  logic               capInB,
  input  logic [1:0]         inSel,
  input  logic               capModeEn,
  input  logic [1:0]         edgeSel,
  input  logic               intEnable,
  input  logic               intAck,
  input  logic               wrEn,
  input  logic [TIMER_W-1:0] wrData,
  input  logic               rdStrobe,
  output logic [TIMER_W-1:0] regValue,
  output logic               flag,
  output logic               irq,
  output logic               overflow
);

  ccStrobe_t strb;
  logic      cmpEq;

  cc_chan_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .capInA    (capInA),
    .capInB    (capInB),
    .inSel     (inSel),
    .capModeEn (capModeEn),
    .edgeSel   (edgeSel),
    .wrEn      (wrEn),
    .cmpEq     (cmpEq),
    .strb      (strb)
  );

  cc_chan_datapath #(.TIMER_W(TIMER_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .timerCount (timerCount),
    .wrData     (wrData),
    .intAck     (intAck),
    .rdStrobe   (rdStrobe),
    .regValue   (regValue),
    .flag       (flag),
    .overflow   (overflow),
    .cmpEq      (cmpEq)
  );

  assign irq = flag & intEnable;

endmodule

// File: rtl/cc_chan_checker.sv
module cc_chan_checker
  import cc_chan_pkg::*;
#(
  parameter int TIMER_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic [TIMER_W-1:0] timerCount,
  input logic               capModeEn,
  input logic               intEnable,
  input logic               intAck,
  input logic               wrEn,
  input logic [TIMER_W-1:0] wrData,
  input logic               rdStrobe,
  input logic [TIMER_W-1:0] regValue,
  input logic               flag,
  input logic               irq,
  input logic               overflow,
  input ccStrobe_t          strb
);

  AST_CMP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (!capModeEn && timerCount == regValue) |=> flag); // R2
  AST_CAP_LOADS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCapture |=> (regValue == $past(timerCount) && flag)); // R3
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    !intEnable |-> !irq); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !strb.setFlag) |=> !flag); // R7
  AST_MODE_SWITCH_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (capModeEn && !$past(capModeEn)) |-> !strb.loadCapture); // R8
  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !strb.loadCapture) |=> regValue == $past(wrData)); // R9
  AST_READ_CLEARS_OVF: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe |=> !overflow); // R10

endmodule

bind cap_cmp_channel cc_chan_checker #(.TIMER_W(TIMER_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .timerCount (timerCount),
  .capModeEn  (capModeEn),
  .intEnable  (intEnable),
  .intAck     (intAck),
  .wrEn       (wrEn),
  .wrData     (wrData),
  .rdStrobe   (rdStrobe),
  .regValue   (regValue),
  .flag       (flag),
  .irq        (irq),
  .overflow   (overflow),
  .strb       (strb)
);

// File: tb/tb_cap_cmp_channel.sv
`timescale 1ns/1ps
module tb_cap_cmp_channel;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] timerCount = '0;
  logic        capInA = 1'b0, capInB = 1'b0;
  logic [1:0]  inSel = 2'd2, edgeSel = 2'd0;
  logic        capModeEn = 1'b0, intEnable = 1'b0, intAck = 1'b0;
  logic        wrEn = 1'b0, rdStrobe = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] regValue;
  logic        flag, irq, overflow;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  cap_cmp_channel dut (
    .clk(clk), .rstN(rstN), .timerCount(timerCount), .capInA(capInA),
    .capInB(capInB), .inSel(inSel), .capModeEn(capModeEn), .edgeSel(edgeSel),
    .intEnable(intEnable), .intAck(intAck), .wrEn(wrEn), .wrData(wrData),
    .rdStrobe(rdStrobe), .regValue(regValue), .flag(flag), .irq(irq),
    .overflow(overflow)
  );

  always #2.5 clk = ~clk;
  always @(negedge clk) timerCount <= timerCount + 16'd1;

  // behavioural reference model
  logic [15:0] mReg;
  bit mFlag, mOvf, mUnread, mPrevMode;
  bit hist[$];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mReg = '0; mFlag = 0; mOvf = 0; mUnread = 0; mPrevMode = 0;
      hist = '{1'b0, 1'b0, 1'b0};
    end else begin
      bit lvl, cur, old, hit, cap, hitCmp;
      lvl = (inSel == 2'd0) ? capInA : (inSel == 2'd1) ? capInB : inSel[0];
      cur = hist[1];
      old = hist[2];
      hit = (edgeSel == 2'd1 && cur && !old) || (edgeSel == 2'd2 && !cur && old) ||
            (edgeSel == 2'd3 && cur != old);
      cap = capModeEn && mPrevMode && hit;
      hitCmp = !capModeEn && (timerCount == mReg);
      if (cap) mReg = timerCount; else if (wrEn) mReg = wrData;
      if (cap || hitCmp) mFlag = 1; else if (intAck) mFlag = 0;
      if (rdStrobe) mOvf = 0; else if (cap && mUnread) mOvf = 1;
      if (cap) mUnread = 1; else if (rdStrobe) mUnread = 0;
      hist.push_front(lvl);
      void'(hist.pop_back());
      mPrevMode = capModeEn;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rstN && !done) begin
      chk("R3 R9 model regValue", regValue, mReg);
      chk("R2 R7 model flag", flag, mFlag);
      chk("R6 model irq", irq, mFlag && intEnable);
      chk("R10 model overflow", overflow, mOvf);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic ackFlag();
    intAck = 1; tick(); intAck = 0;
  endtask

  logic [15:0] c, keep;

  initial begin
    tick(3);
    chk("R1 reset regValue", regValue, 0);
    chk("R1 reset flag", flag, 0);
    chk("R1 reset irq", irq, 0);
    chk("R1 reset overflow", overflow, 0);
    rstN = 1;
    tick(2);

    // compare mode
    c = timerCount;
    wrEn = 1; wrData = c + 16'd10;
    tick();
    wrEn = 0;
    chk("R9 write loads", regValue, 16'(c + 16'd10));
    tick(8);
    chk("R2 no early match", flag, 0);
    tick();
    chk("R2 match sets flag", flag, 1);
    chk("R6 irq masked", irq, 0);
    intEnable = 1; #1;
    chk("R6 irq enabled", irq, 1);
    tick();
    ackFlag();
    chk("R7 ack clears", flag, 0);

    // acknowledge at the same edge as a match
    c = timerCount;
    wrEn = 1; wrData = c + 16'd3;
    tick(); wrEn = 0;
    tick(); intAck = 1;
    tick(); intAck = 0;
    chk("R7 set wins over ack", flag, 1);
    ackFlag();

    // capture on rising edge of pin A
    capModeEn = 1; inSel = 2'd0; edgeSel = 2'd1;
    tick(3);
    keep = regValue;
    c = timerCount; capInA = 1;
    tick(2);
    chk("R3 not loaded early", regValue, keep);
    tick();
    chk("R3 capture value", regValue, 16'(c + 16'd3));
    chk("R3 capture flag", flag, 1);
    ackFlag();

    // falling edge ignored in rise mode, then fall mode
    keep = regValue;
    capInA = 0; tick(5);
    chk("R4 fall ignored in rise mode", regValue, keep);
    edgeSel = 2'd2; capInA = 1; tick(5);
    chk("R4 rise ignored in fall mode", regValue, keep);
    c = timerCount; capInA = 0; tick(3);
    chk("R4 fall captured", regValue, 16'(c + 16'd3));
    edgeSel = 2'd0; keep = regValue;
    capInA = 1; tick(4); capInA = 0; tick(4);
    chk("R4 mode 0 no capture", regValue, keep);

    // pin B selection
    inSel = 2'd1; edgeSel = 2'd3; tick(4);
    keep = regValue;
    capInA = 1; tick(5);
    chk("R5 unselected pin ignored", regValue, keep);
    c = timerCount; capInB = 1; tick(3);
    chk("R5 pin B captured", regValue, 16'(c + 16'd3));

    // software capture by toggling the select
    edgeSel = 2'd0; inSel = 2'd2; tick(4);
    edgeSel = 2'd3; rdStrobe = 1; tick(); rdStrobe = 0;
    chk("R10 read clears overflow", overflow, 0);
    c = timerCount; inSel = 2'd3; tick(3);
    chk("R5 software capture high", regValue, 16'(c + 16'd3));
    chk("R10 no overflow on first", overflow, 0);
    c = timerCount; inSel = 2'd2; tick(3);
    chk("R5 software capture low", regValue, 16'(c + 16'd3));
    chk("R10 overflow on unread", overflow, 1);
    rdStrobe = 1; tick(); rdStrobe = 0;
    chk("R10 read clears", overflow, 0);

    // write coinciding with capture
    c = timerCount; inSel = 2'd3;
    tick(2); wrEn = 1; wrData = 16'hBEEF;
    tick(); wrEn = 0;
    chk("R9 capture wins over write", regValue, 16'(c + 16'd3));
    wrEn = 1; wrData = 16'h1234; tick(); wrEn = 0;
    chk("R9 plain write", regValue, 16'h1234);

    // capture at the mode switch edge is dropped
    capModeEn = 0; ackFlag(); tick(2);
    inSel = 2'd2; tick(2);
    capModeEn = 1; tick();
    chk("R8 switch edge ignored", regValue, 16'h1234);
    tick(3);
    c = timerCount; inSel = 2'd3; tick(3);
    chk("R8 capture after switch", regValue, 16'(c + 16'd3));

    // read and capture together
    c = timerCount; inSel = 2'd2; tick(2);
    rdStrobe = 1; tick(); rdStrobe = 0;
    chk("R10 read with capture", overflow, 0);

    tick(5);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule